// File: doc/BRIEF.md
# Memory-Mapped LCD and LED Interface

This block sits between a small 16-bit word-addressed processor and a handful of board peripherals. It decodes a 64K-word address space: a few fixed addresses reach an LED output register, a button input register and an LCD backlight bit, and two address windows reach a 32-character LCD text buffer. Every other address reaches general-purpose RAM held inside the block.

The text buffer has a single store but two views. In the narrow view each word holds one character. In the packed view each word holds two neighbouring characters. A write through either view lands in the same store, so the two views always agree. The whole buffer is also driven out continuously on a flat port so that a display controller can read it.

All state changes on the falling edge of `clk`. The read data port is a register loaded on that same edge. The processor bus has no back-pressure: the block accepts one access on every falling edge, and the read result of that access sits on `rdata` until the next falling edge. Control and status pins are plain levels.

Top module: `mmio_lcd_led_map`

## Requirements
- R1: While `rst_n` is low, `led` is 0, `backlight` is 0, `rdata` is 0 and every character of `lcd_text` is 8'h20.
- R2: A write to address 16'h0800 loads `wdata[7:0]` into `led`. A read of that address returns `{8'h00, led}`.
- R3: A read of address 16'h0801 returns `{13'b0, buttons}`. A write to that address changes no LED, backlight, text or RAM state.
- R4: A write to address 16'h0802 loads `wdata[0]` into `backlight`. A read of that address returns `{15'b0, backlight}`.
- R5: A write to address 16'h0820+i (i = 0..31) loads `wdata[7:0]` into character i. A read returns `{8'h00, character i}`. Character i appears on `lcd_text[8*i+7 : 8*i]`.
- R6: A write to address 16'h0840+j (j = 0..15) loads `wdata[15:8]` into character 2j and `wdata[7:0]` into character 2j+1. A read returns `{character 2j, character 2j+1}`.
- R7: The narrow and packed views share one store, so a read through one view returns data that was written through the other.
- R8: Every address not named in R2 to R6 reaches RAM at word index `addr mod RAM_WORDS` (256 by default), holding all 16 bits. This includes the unused gaps next to the peripherals.
- R9: State and `rdata` change only on the falling edge of `clk`. `rdata` holds the result for the address that was presented at the previous falling edge.
- R10: When a write happens, `rdata` returns the content that the location held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock; the falling edge is the active edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Word address |
| wdata | input | 16 | Write data |
| we | input | 1 | Write enable for the access at this falling edge |
| rdata | output | 16 | Registered read data |
| buttons | input | 3 | Button levels |
| led | output | 8 | LED register |
| backlight | output | 1 | LCD backlight control |
| lcd_text | output | 256 | The 32 characters, with character i in bits 8i+7:8i |

## Verification
A corrupted character shows up on `lcd_text` right after the falling edge that caused it. It also shows up one edge later on `rdata` when either view is read. A fault that splits the two views shows only on a read through the other view, so the sweeps write through one view and read back through the other. A wrong RAM index or a decode overlap shows as a miscompare on the aliased read-back sweep, or as an unexpected change on `led` or `lcd_text` during RAM traffic.

// File: rtl/mmio_map_pkg.sv
package mmio_map_pkg;
  // Region selected by the current address.
  typedef enum logic [2:0] {
    RG_RAM  = 3'd0,
    RG_LED  = 3'd1,
    RG_BTN  = 3'd2,
    RG_LITE = 3'd3,
    RG_CHAR = 3'd4,
    RG_PAIR = 3'd5
  } region_e;
endpackage

// File: rtl/mmio_addr_decode.sv
module mmio_addr_decode
  import mmio_map_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          NCHAR     = 32,
  parameter logic [15:0] LED_ADDR  = 16'h0800,
  parameter logic [15:0] BTN_ADDR  = 16'h0801,
  parameter logic [15:0] LITE_ADDR = 16'h0802,
  parameter logic [15:0] CHAR_BASE = 16'h0820,
  parameter logic [15:0] PAIR_BASE = 16'h0840,
  localparam int         CIX       = $clog2(NCHAR)
) (
  input  logic [AW-1:0]  addr,
  output region_e        region,
  output logic [CIX-1:0] cidx
);
  localparam int NPAIR = NCHAR / 2;

  logic [AW-1:0] off_c, off_p;
  logic hit_led, hit_btn, hit_lite, hit_char, hit_pair;

  always_comb begin
    off_c    = addr - CHAR_BASE[AW-1:0];
    off_p    = addr - PAIR_BASE[AW-1:0];
    hit_led  = (addr == LED_ADDR[AW-1:0]);
    hit_btn  = (addr == BTN_ADDR[AW-1:0]);
    hit_lite = (addr == LITE_ADDR[AW-1:0]);
    hit_char = (off_c < AW'(NCHAR));
    hit_pair = (off_p < AW'(NPAIR));
  end

  always_comb begin
    region = RG_RAM;
    cidx   = '0;
    if (hit_led)       region = RG_LED;
    else if (hit_btn)  region = RG_BTN;
    else if (hit_lite) region = RG_LITE;
    else if (hit_char) begin
      region = RG_CHAR;
      cidx   = off_c[CIX-1:0];
    end else if (hit_pair) begin
      region = RG_PAIR;
      cidx   = {off_p[CIX-2:0], 1'b0};
    end
  end

  // R8: the peripheral windows never overlap, so RAM is left only when exactly one is hit
  always_comb begin
    p_single_hit_r8 : assert ($onehot0({hit_led, hit_btn, hit_lite, hit_char, hit_pair}))
      else $error("address decodes to more than one peripheral");
  end
endmodule

// File: rtl/mmio_ctrl_regs.sv
module mmio_ctrl_regs #(
  parameter int LED_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_led,
  input  logic             wr_lite,
  input  logic [LED_W-1:0] wd_led,
  input  logic             wd_lite,
  output logic [LED_W-1:0] led,
  output logic             backlight
);
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led       <= '0;
      backlight <= 1'b0;
    end else begin
      if (wr_led)  led       <= wd_led;
      if (wr_lite) backlight <= wd_lite;
    end
  end

  p_led_load_r2 : assert property (@(negedge clk) disable iff (!rst_n)
    wr_led |=> led == $past(wd_led));
  p_led_hold_r3 : assert property (@(negedge clk) disable iff (!rst_n)
    !wr_led |=> $stable(led));
  p_lite_load_r4 : assert property (@(negedge clk) disable iff (!rst_n)
    wr_lite |=> backlight == $past(wd_lite));
endmodule

// File: rtl/mmio_text_buf.sv
module mmio_text_buf #(
  parameter int          NCHAR = 32,
  parameter int          CW    = 8,
  parameter logic [7:0]  FILL  = 8'h20,
  localparam int         CIX   = $clog2(NCHAR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_one,
  input  logic              we_pair,
  input  logic [CIX-1:0]    idx,
  input  logic [2*CW-1:0]   wd,
  output logic [CW-1:0]     rd_one,
  output logic [2*CW-1:0]   rd_pair,
  output logic [NCHAR*CW-1:0] text
);
  logic [CW-1:0] chr [NCHAR];
  logic [CIX-1:0] idx_nb;

  assign idx_nb = idx | CIX'(1);

  for (genvar k = 0; k < NCHAR; k++) begin : g_chr
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)
        chr[k] <= CW'(FILL);
      else if (we_one && idx == CIX'(k))
        chr[k] <= wd[CW-1:0];
      else if (we_pair && idx == CIX'(k))
        chr[k] <= wd[2*CW-1:CW];
      else if (we_pair && idx_nb == CIX'(k))
        chr[k] <= wd[CW-1:0];
    end
    assign text[k*CW +: CW] = chr[k];
  end

  assign rd_one  = chr[idx];
  assign rd_pair = {chr[idx], chr[idx_nb]};

  // R5: the display image moves only on a write through one of the two views
  p_text_hold_r5 : assert property (@(negedge clk) disable iff (!rst_n)
    !(we_one || we_pair) |=> $stable(text));
  // R6: the packed write places its high byte in the even character
  p_pair_high_r6 : assert property (@(negedge clk) disable iff (!rst_n)
    we_pair |=> rd_pair == $past(wd) || idx != $past(idx));
endmodule

// File: rtl/mmio_word_ram.sv
module mmio_word_ram #(
  parameter int  DEPTH = 256,
  parameter int  DW    = 16,
  localparam int RAW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [RAW-1:0] idx,
  input  logic [DW-1:0]  wd,
  output logic [DW-1:0]  rd
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(negedge clk) begin
    if (we) mem[idx] <= wd;
  end

  assign rd = mem[idx];
endmodule

// File: rtl/mmio_lcd_led_map.sv
module mmio_lcd_led_map
  import mmio_map_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          DW        = 16,
  parameter int          CW        = 8,
  parameter int          NCHAR     = 32,
  parameter int          RAM_WORDS = 256,
  parameter int          LED_W     = 8,
  parameter int          BTN_W     = 3,
  parameter logic [15:0] LED_ADDR  = 16'h0800,
  parameter logic [15:0] BTN_ADDR  = 16'h0801,
  parameter logic [15:0] LITE_ADDR = 16'h0802,
  parameter logic [15:0] CHAR_BASE = 16'h0820,
  parameter logic [15:0] PAIR_BASE = 16'h0840,
  parameter logic [7:0]  FILL      = 8'h20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       wdata,
  input  logic                we,
  output logic [DW-1:0]       rdata,
  input  logic [BTN_W-1:0]    buttons,
  output logic [LED_W-1:0]    led,
  output logic                backlight,
  output logic [NCHAR*CW-1:0] lcd_text
);
  localparam int CIX = $clog2(NCHAR);
  localparam int RAW = $clog2(RAM_WORDS);

  region_e        region;
  logic [CIX-1:0] cidx;
  logic [CW-1:0]  rd_one;
  logic [DW-1:0]  rd_pair, ram_q, rd_mux;

  mmio_addr_decode #(
    .AW(AW), .NCHAR(NCHAR), .LED_ADDR(LED_ADDR), .BTN_ADDR(BTN_ADDR),
    .LITE_ADDR(LITE_ADDR), .CHAR_BASE(CHAR_BASE), .PAIR_BASE(PAIR_BASE)
  ) u_dec (
    .addr(addr), .region(region), .cidx(cidx)
  );

  mmio_ctrl_regs #(.LED_W(LED_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_led(we && region == RG_LED),
    .wr_lite(we && region == RG_LITE),
    .wd_led(wdata[LED_W-1:0]), .wd_lite(wdata[0]),
    .led(led), .backlight(backlight)
  );

  mmio_text_buf #(.NCHAR(NCHAR), .CW(CW), .FILL(FILL)) u_txt (
    .clk(clk), .rst_n(rst_n),
    .we_one(we && region == RG_CHAR),
    .we_pair(we && region == RG_PAIR),
    .idx(cidx), .wd(wdata),
    .rd_one(rd_one), .rd_pair(rd_pair), .text(lcd_text)
  );

  mmio_word_ram #(.DEPTH(RAM_WORDS), .DW(DW)) u_ram (
    .clk(clk), .we(we && region == RG_RAM),
    .idx(addr[RAW-1:0]), .wd(wdata), .rd(ram_q)
  );

  always_comb begin
    unique case (region)
      RG_LED:  rd_mux = DW'(led);
      RG_BTN:  rd_mux = DW'(buttons);
      RG_LITE: rd_mux = DW'(backlight);
      RG_CHAR: rd_mux = DW'(rd_one);
      RG_PAIR: rd_mux = rd_pair;
      default: rd_mux = ram_q;
    endcase
  end

  // Read data is captured before any write on the same edge lands (R10).
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_mux;
  end

  p_btn_read_r3 : assert property (@(negedge clk) disable iff (!rst_n)
    region == RG_BTN |=> rdata == DW'($past(buttons)));
  p_rd_pair_r7 : assert property (@(negedge clk) disable iff (!rst_n)
    region == RG_PAIR |=> rdata == $past(rd_pair));
endmodule

// File: tb/sim_mmio_lcd_led_map.sv
module sim_mmio_lcd_led_map;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic we = 1'b0;
  logic [2:0] buttons = '0;
  logic [15:0] rdata;
  logic [7:0] led;
  logic backlight;
  logic [255:0] lcd_text;

  int n_chk = 0, n_bad = 0;
  logic [7:0]  txt [32];
  logic [15:0] ram [256];
  logic [7:0]  led_m;
  logic        bl_m;
  logic [15:0] got;

  always #2.5 clk = ~clk;

  mmio_lcd_led_map u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we),
    .rdata(rdata), .buttons(buttons), .led(led), .backlight(backlight),
    .lcd_text(lcd_text)
  );

  task automatic chk(input string tag, input logic [255:0] g, input logic [255:0] e);
    n_chk++;
    if (g !== e) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", tag, g, e);
    end
  endtask

  function automatic logic [255:0] img();
    logic [255:0] v;
    for (int i = 0; i < 32; i++) v[i*8 +: 8] = txt[i];
    return v;
  endfunction

  // One access: inputs set after a rising edge, result taken after the falling edge.
  task automatic xfer(input logic [15:0] a, input logic [15:0] d, input logic w, output logic [15:0] r);
    @(posedge clk); #1;
    addr = a; wdata = d; we = w;
    @(negedge clk); #1;
    r = rdata;
    we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) txt[i] = 8'h20;
    led_m = 0; bl_m = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 led", 256'(led), 0);
    chk("R1 backlight", 256'(backlight), 0);
    chk("R1 rdata", 256'(rdata), 0);
    chk("R1 lcd_text", lcd_text, img());
    rst_n = 1'b1;

    // R2 LED sweep; R10 read during write returns the old value
    for (int v = 0; v < 256; v++) begin
      xfer(16'h0800, {8'hA5, 8'(v)}, 1'b1, got);
      chk("R10 led old", 256'(got), 256'({8'h00, led_m}));
      led_m = 8'(v);
      chk("R2 led port", 256'(led), 256'(led_m));
    end
    xfer(16'h0800, 16'h0, 1'b0, got);
    chk("R2 led read", 256'(got), 256'({8'h00, led_m}));

    // R4 backlight
    for (int v = 0; v < 4; v++) begin
      xfer(16'h0802, 16'hFFFE | 16'(v & 1), 1'b1, got);
      bl_m = 1'(v & 1);
      chk("R4 backlight port", 256'(backlight), 256'(bl_m));
      xfer(16'h0802, 16'h0, 1'b0, got);
      chk("R4 backlight read", 256'(got), 256'({15'b0, bl_m}));
    end

    // R3 button reads
    for (int b = 0; b < 8; b++) begin
      buttons = 3'(b);
      xfer(16'h0801, 16'h0, 1'b0, got);
      chk("R3 button read", 256'(got), 256'(b));
    end

    // R5 narrow writes, R7 packed read-back
    for (int i = 0; i < 32; i++) begin
      xfer(16'h0820 + 16'(i), {8'hEE, 8'((i * 7 + 8'h41) & 8'hFF)}, 1'b1, got);
      txt[i] = 8'((i * 7 + 8'h41) & 8'hFF);
    end
    chk("R5 lcd_text after narrow writes", lcd_text, img());
    for (int j = 0; j < 16; j++) begin
      xfer(16'h0840 + 16'(j), 16'h0, 1'b0, got);
      chk("R7 packed read of narrow data", 256'(got), 256'({txt[2*j], txt[2*j+1]}));
    end

    // R6 packed writes, R7 narrow read-back
    for (int j = 0; j < 16; j++) begin
      xfer(16'h0840 + 16'(j), 16'((j * 16'h1357 + 16'h2468) & 16'hFFFF), 1'b1, got);
      txt[2*j]   = 8'(((j * 16'h1357 + 16'h2468) >> 8) & 8'hFF);
      txt[2*j+1] = 8'((j * 16'h1357 + 16'h2468) & 8'hFF);
    end
    chk("R6 lcd_text after packed writes", lcd_text, img());
    for (int i = 0; i < 32; i++) begin
      xfer(16'h0820 + 16'(i), 16'h0, 1'b0, got);
      chk("R5 narrow read", 256'(got), 256'({8'h00, txt[i]}));
    end

    // R8 RAM sweep with aliased read-back
    for (int i = 0; i < 256; i++) begin
      ram[i] = 16'((i * 16'h9E37 + 16'h1234) & 16'hFFFF);
      xfer(16'h1000 + 16'(i), ram[i], 1'b1, got);
    end
    chk("R8 RAM traffic leaves text", lcd_text, img());
    chk("R8 RAM traffic leaves led", 256'(led), 256'(led_m));
    for (int i = 0; i < 256; i++) begin
      xfer(16'h3000 + 16'(i), 16'h0, 1'b0, got);
      chk("R8 RAM alias read", 256'(got), 256'(ram[i]));
    end
    // R8 gap next to the peripherals falls to RAM
    xfer(16'h0803, 16'hBEEF, 1'b1, got);
    ram[3] = 16'hBEEF;
    xfer(16'h0003, 16'h0, 1'b0, got);
    chk("R8 gap write seen at index 3", 256'(got), 256'(16'hBEEF));
    xfer(16'h0850, 16'hC0DE, 1'b1, got);
    xfer(16'hF050, 16'h0, 1'b0, got);
    chk("R8 gap above packed window", 256'(got), 256'(16'hC0DE));
    ram[8'h50] = 16'hC0DE;

    // R3 writes to the button address are ignored
    xfer(16'h0801, 16'hFFFF, 1'b1, got);
    chk("R3 ignore led", 256'(led), 256'(led_m));
    chk("R3 ignore backlight", 256'(backlight), 256'(bl_m));
    chk("R3 ignore text", lcd_text, img());
    xfer(16'h1001, 16'h0, 1'b0, got);
    chk("R3 ignore RAM idx1", 256'(got), 256'(ram[1]));

    // R9 rdata holds until the falling edge
    xfer(16'h0800, 16'h0, 1'b0, got);
    @(posedge clk); #1;
    addr = 16'h0801; buttons = 3'd5;
    #1;
    chk("R9 rdata before falling edge", 256'(rdata), 256'({8'h00, led_m}));
    @(negedge clk); #1;
    chk("R9 rdata after falling edge", 256'(rdata), 256'(5));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule